// File: doc/BRIEF.md
# Tile Sharer Directory

This block keeps the private write-through data caches of the cores in one tile coherent with each other. It sits next to the tile's shared second-level cache and holds a duplicate copy of every core's first-level tags, one set of two ways per core. From these tags it can tell, for any line, which cores currently hold it. Cores report line fills and evictions. Every store is written through and passes through this block. Coherence does not reach beyond the tile, and nothing is produced for other tiles.

A store is accepted when `st_rdy` is high. The block then sends an invalidation to every other core that holds the line. The invalidations go out one per cycle, lowest core number first. Each invalidated core's duplicate tag is dropped as its invalidation goes out. When the last invalidation has been sent, the block pulses `st_ack` to acknowledge the store. The writer keeps its own copy. A query port reports, with no added latency, whether a line is held by no core at all, so the second-level cache knows when no first-level copy exists.

Top module: `tile_sharer_dir`

## Requirements
- R1: After reset, `st_rdy` is 1, `inv_vld` and `st_ack` are 0, and `qry_none` is 1 for every address.
- R2: An address splits into a set index `addr[SW-1:0]` and a tag `addr[AW-1:SW]`. After a fill by core c into way w, the line is held, so `qry_none` reads 0 for that address in the next cycle.
- R3: An eviction names a core, a set and a way, and clears only that way. If the same core still holds the line in its other way, the line stays held.
- R4: An accepted store from core c invalidates every core that holds the line, except c. Core c's copy stays valid.
- R5: Invalidations are issued one per cycle in ascending core order. The first appears in the cycle after the store is accepted, and `inv_addr` carries the store's address.
- R6: `st_ack` pulses for one cycle, in the cycle after the last invalidation, or in the cycle after acceptance if there is nothing to invalidate. `st_rdy` stays 0 from acceptance up to and including the acknowledge cycle.
- R7: A fill for the store's line that arrives in the same cycle as the accepted store is treated as following the store. The filling core is not invalidated, and it holds the line afterwards.
- R8: `qry_none` is 1 exactly when no core holds a valid way whose tag matches the queried address's set and tag. A line in the same set with a different tag does not count.
- R9: A core that has been invalidated no longer holds the line. Once the writer also evicts its copy, `qry_none` reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fill_vld | input | 1 | A core has filled a line |
| fill_core | input | CW | Core that filled the line |
| fill_way | input | 1 | Way that was filled |
| fill_addr | input | AW | Line address of the fill |
| evict_vld | input | 1 | A core has evicted a line |
| evict_core | input | CW | Core that evicted the line |
| evict_way | input | 1 | Way of the victim |
| evict_set | input | SW | Set of the victim |
| st_vld | input | 1 | Write-through store request |
| st_core | input | CW | Core that issued the store |
| st_addr | input | AW | Line address of the store |
| st_rdy | output | 1 | Block can accept a store |
| inv_vld | output | 1 | Invalidation valid this cycle |
| inv_core | output | CW | Core being invalidated |
| inv_addr | output | AW | Line being invalidated |
| st_ack | output | 1 | Store acknowledged to its writer |
| qry_addr | input | AW | Line address to query |
| qry_none | output | 1 | The queried line is held by no core |

## Verification
A fill or an eviction changes the tag state at the clock edge that samples it. The query result is combinational, so the bench reads `qry_none` at the next falling edge. After a store is accepted at edge k, the n invalidations appear at the falling edges following edges k through k+n-1. The acknowledge appears at the falling edge after edge k+n. The bench drives every input on a falling edge and walks the same schedule one cycle at a time, comparing one expected invalidation per cycle. It sweeps every sharer subset of the eight cores against every writer.

// File: rtl/tile_sharer_dir.sv
module tile_sharer_dir #(
  parameter int NCORE = 8,
  parameter int SETS  = 64,
  parameter int TW    = 20,
  localparam int CW   = $clog2(NCORE),
  localparam int SW   = $clog2(SETS),
  localparam int AW   = SW + TW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fill_vld,
  input  logic [CW-1:0] fill_core,
  input  logic          fill_way,
  input  logic [AW-1:0] fill_addr,
  input  logic          evict_vld,
  input  logic [CW-1:0] evict_core,
  input  logic          evict_way,
  input  logic [SW-1:0] evict_set,
  input  logic          st_vld,
  input  logic [CW-1:0] st_core,
  input  logic [AW-1:0] st_addr,
  output logic          st_rdy,
  output logic          inv_vld,
  output logic [CW-1:0] inv_core,
  output logic [AW-1:0] inv_addr,
  output logic          st_ack,
  input  logic [AW-1:0] qry_addr,
  output logic          qry_none
);

  logic [TW-1:0]    tags [NCORE][SETS][2];
  logic             vld  [NCORE][SETS][2];
  logic             busy;
  logic [NCORE-1:0] pend;
  logic [CW-1:0]    wr_q;
  logic [AW-1:0]    addr_q;

  function automatic logic [NCORE-1:0] holders(input logic [AW-1:0] a);
    logic [NCORE-1:0] h;
    h = '0;
    for (int c = 0; c < NCORE; c++)
      for (int w = 0; w < 2; w++)
        if (vld[c][a[SW-1:0]][w] && tags[c][a[SW-1:0]][w] == a[AW-1:SW]) h[c] = 1'b1;
    return h;
  endfunction

  function automatic logic [CW-1:0] lowest(input logic [NCORE-1:0] m);
    logic [CW-1:0] i;
    i = '0;
    for (int k = NCORE - 1; k >= 0; k--)
      if (m[k]) i = CW'(k);
    return i;
  endfunction

  logic             acc;
  logic [NCORE-1:0] st_mask, same_fill;

  assign acc       = st_vld && !busy;
  assign same_fill = (fill_vld && fill_addr == st_addr) ? (NCORE'(1) << fill_core) : '0;
  assign st_mask   = holders(st_addr) & ~(NCORE'(1) << st_core) & ~same_fill;

  assign st_rdy   = !busy;
  assign inv_vld  = busy && |pend;
  assign inv_core = lowest(pend);
  assign inv_addr = addr_q;
  assign st_ack   = busy && pend == '0;
  assign qry_none = holders(qry_addr) == '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      pend   <= '0;
      wr_q   <= '0;
      addr_q <= '0;
    end else if (acc) begin
      busy   <= 1'b1;
      pend   <= st_mask;
      wr_q   <= st_core;
      addr_q <= st_addr;
    end else if (busy) begin
      if (|pend) pend[inv_core] <= 1'b0;
      else       busy <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < NCORE; c++)
        for (int s = 0; s < SETS; s++)
          for (int w = 0; w < 2; w++)
            vld[c][s][w] <= 1'b0;
    end else begin
      if (inv_vld)
        for (int w = 0; w < 2; w++)
          if (tags[inv_core][addr_q[SW-1:0]][w] == addr_q[AW-1:SW])
            vld[inv_core][addr_q[SW-1:0]][w] <= 1'b0;
      if (evict_vld) vld[evict_core][evict_set][evict_way] <= 1'b0;
      if (fill_vld)  vld[fill_core][fill_addr[SW-1:0]][fill_way] <= 1'b1;
    end
  end

  always_ff @(posedge clk)
    if (fill_vld) tags[fill_core][fill_addr[SW-1:0]][fill_way] <= fill_addr[AW-1:SW];

  // R4
  inv_not_writer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inv_vld |-> inv_core != wr_q);

  // R5
  inv_ascending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_vld && $past(inv_vld) && $past(busy) && !$past(acc)) |-> inv_core > $past(inv_core));

  // R6
  accept_progress_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> (inv_vld || st_ack) && !st_rdy);

  // R3
  evict_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evict_vld && !(fill_vld && fill_core == evict_core && fill_way == evict_way
                    && fill_addr[SW-1:0] == evict_set))
    |=> !vld[$past(evict_core)][$past(evict_set)][$past(evict_way)]);

endmodule

// File: tb/sim_tile_sharer_dir.sv
module sim_tile_sharer_dir;
  localparam int NCORE = 8, SETS = 64, TW = 20;
  localparam int CW = 3, SW = 6, AW = SW + TW;
  localparam time TCLK = 10;

  logic clk = 0, rst_n = 0;
  logic fill_vld = 0, fill_way = 0, evict_vld = 0, evict_way = 0, st_vld = 0;
  logic [CW-1:0] fill_core = 0, evict_core = 0, st_core = 0;
  logic [AW-1:0] fill_addr = 0, st_addr = 0, qry_addr = 0;
  logic [SW-1:0] evict_set = 0;
  logic st_rdy, inv_vld, st_ack, qry_none;
  logic [CW-1:0] inv_core;
  logic [AW-1:0] inv_addr;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(TCLK/2) clk = ~clk;

  tile_sharer_dir #(.NCORE(NCORE), .SETS(SETS), .TW(TW)) u0 (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic fill(input int c, input int w, input logic [AW-1:0] a);
    fill_vld = 1; fill_core = CW'(c); fill_way = w[0]; fill_addr = a;
    step(); fill_vld = 0;
  endtask

  task automatic evict(input int c, input int w, input logic [AW-1:0] a);
    evict_vld = 1; evict_core = CW'(c); evict_way = w[0]; evict_set = a[SW-1:0];
    step(); evict_vld = 0;
  endtask

  task automatic query(input logic [AW-1:0] a, input bit exp, input string req);
    qry_addr = a; #1;
    chk(qry_none == exp, req, int'(qry_none), int'(exp));
  endtask

  // store with an optional same-cycle fill; exp holds the cores to invalidate
  task automatic store(input int c, input logic [AW-1:0] a, input logic [NCORE-1:0] exp,
                       input bit with_fill, input int fc);
    st_vld = 1; st_core = CW'(c); st_addr = a;
    if (with_fill) begin fill_vld = 1; fill_core = CW'(fc); fill_way = 1; fill_addr = a; end
    chk(st_rdy == 1, "R6", int'(st_rdy), 1);
    step(); st_vld = 0; fill_vld = 0;
    for (int k = 0; k < NCORE; k++) if (exp[k]) begin
      chk(inv_vld && inv_core == CW'(k) && inv_addr == a && !st_ack, "R5",
          int'(inv_vld) * 16 + int'(inv_core), 16 + k);
      chk(st_rdy == 0, "R6", int'(st_rdy), 0);
      step();
    end
    chk(st_ack && !inv_vld, "R6", int'(st_ack) * 2 + int'(inv_vld), 2);
    step();
    chk(!st_ack && st_rdy, "R6", int'(st_ack), 0);
  endtask

  initial begin
    logic [AW-1:0] a, b;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk(st_rdy && !inv_vld && !st_ack, "R1", int'({st_rdy, inv_vld, st_ack}), 4);
    query(26'h0, 1, "R1");
    query(26'h3ff_ffff, 1, "R1");

    // R2, R3: fill and per-way eviction
    a = {20'h00abc, 6'd5};
    fill(4, 1, a); query(a, 0, "R2");
    fill(4, 0, a);
    evict(4, 0, a); query(a, 0, "R3");
    evict(4, 1, a); query(a, 1, "R3");

    // R8: same set, different tag
    a = {20'h00011, 6'd9}; b = {20'h00022, 6'd9};
    fill(2, 0, a);
    query(b, 1, "R8"); query(a, 0, "R8");
    store(0, b, '0, 0, 0);
    query(a, 0, "R8");
    evict(2, 0, a); query(a, 1, "R8");

    // R7: same-cycle fill of the stored line
    a = {20'h0beef, 6'd17};
    fill(1, 0, a); fill(2, 0, a);
    store(0, a, 8'b0000_0110, 1, 5);
    query(a, 0, "R7");
    evict(5, 1, a); query(a, 1, "R7");

    // R4, R5, R6, R9: every sharer subset against every writer
    for (int m = 0; m < 256; m++)
      for (int w = 0; w < NCORE; w++) begin
        logic [NCORE-1:0] mask, exp;
        mask = NCORE'(m);
        a = {12'h0, mask, 6'(m + w)};
        for (int c = 0; c < NCORE; c++) if (mask[c]) fill(c, c % 2, a);
        query(a, mask == 0, "R2");
        exp = mask & ~(NCORE'(1) << w);
        store(w, a, exp, 0, 0);
        // R4: writer keeps its copy
        query(a, !mask[w], "R4");
        if (mask[w]) evict(w, w % 2, a);
        query(a, 1, "R9");
      end
    done = 1;
  end

  initial begin
    for (int i = 0; i < 200000 && !done; i++) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule